// File: doc/BRIEF.md
# Processor I/O Port with Floating-Bit Decay

This block is the small parallel I/O port that sits at the two lowest addresses of a CPU's memory space. Address 0 holds an 8-bit direction mask (1 = output) and address 1 holds an 8-bit output latch. The block tracks the level of each port pin and returns a read-back byte that mixes the latch, the pin levels and fixed pull-ups. The low three bits of the effective output drive a bank-select bus to an external address decoder. Bits 6 and 7 have no pins. When one of them stops being an output, it holds the level it last had for a set number of clock cycles and then reads as 0. This mimics charge left on a floating node.

Every CPU access goes through the block. Accesses to any address other than 0 or 1 pass to an external RAM port unchanged. A write to address 0 or 1 also updates the RAM cell underneath, but the byte stored is the last byte seen on the CPU bus, not the byte written.

The CPU request uses a valid/ready handshake. A request transfers on a clock edge where `cpu_valid` and `cpu_ready` are both high. When the access needs RAM (any write, or any read outside the port), `cpu_ready` follows `ram_ready` and `ram_valid` follows `cpu_valid`. Reads of the two port addresses never wait. `cpu_valid`, `cpu_we`, `cpu_addr` and `cpu_wdata` must stay stable while the request waits. Read data is combinational and is valid in the cycle of the transfer. A free-running cycle counter, cleared by reset, timestamps the decay.

Top module: `iop_decay_port`

## Requirements
- R1: After reset the direction mask is 0x00, the output latch is 0x3F, the pin levels are 0x3F and both decay cells are empty. A read of address 1 then returns 0x1F, and `bank_sel` is 3'b111.
- R2: When the direction mask or the latch changes, each output pin takes its latch bit and each input pin keeps its level. A read of address 1 returns (latch | ~dir) & (pins | 0x17), before the R3 and R5 adjustments.
- R3: When direction bit 5 is 0, bit 5 of an address-1 read is 0. Bit 4 is never forced.
- R4: `bank_sel` always equals (latch | ~dir) & 3'b111.
- R5: For bit 6 and bit 7, when the direction bit is 0, an address-1 read returns that bit from its decay cell.
- R6: A write to address 0 that changes direction bit 6 (or 7) from 1 to 0 charges that cell with the current latch bit and restarts its timer.
- R7: A write to address 1 charges the cell for bit 6 (or 7) with the written bit only when that direction bit is 1. Cells for input bits are left as they are.
- R8: A charged cell returns its stored bit on reads up to and including cycle T+DECAY_CYCLES, where T is the counter value at the charging edge. A read consulting the cell at any later cycle returns 0 and empties the cell, so later reads return 0.
- R9: A write to address 0 or 1 is also issued to RAM at the same address, with `ram_wdata` equal to `bus_last_byte`.
- R10: An access to any other address is passed to RAM with the same address and write data, and a read returns `ram_rdata`.
- R11: `cpu_ready` equals `ram_ready` for accesses that need RAM and is 1 for port reads. Without a transfer, no port state changes.
- R12: A read of address 0 returns the direction mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid during the transfer |
| bus_last_byte | input | 8 | Last byte seen on the CPU bus |
| bank_sel | output | 3 | Bank-select bus to the decoder |
| ram_valid | output | 1 | RAM request valid |
| ram_ready | input | 1 | RAM ready |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
The bench steps through all 256 direction masks. For each mask it writes eight latch patterns, chosen to cover all-zero, all-one, the reset value, the high pair alone and alternating bits. It checks the read-back and `bank_sel` against an arithmetic model of pins and cells. Pins carried over from earlier masks are what show R2 input-hold errors. The high pair is driven and then floated across many masks, so each cell is charged both from a direction write and from a latch write. A dedicated run reads exactly at the expiry cycle and one cycle later, which separates an off-by-one in R8. RAM-side probes with distinct last-byte and write-data values, and a stalled `ram_ready`, show the forwarding and handshake rules apart.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int BYTE_W   = 8;
  localparam int BANK_W   = 3;
  localparam int FLOAT_LO = 6;   // first pinless bit
  localparam int NCELL    = 2;   // pinless bits 6 and 7
  localparam int SENSE_B  = 5;   // bit forced low when input

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t RST_LATCH = 8'h3F;
  localparam byte_t RST_PINS  = 8'h3F;
  localparam byte_t PULL_MASK = 8'h17;

  typedef enum logic [1:0] {SEL_DIR, SEL_LATCH, SEL_MEM} sel_e;
endpackage

// File: rtl/iop_decay_cell.sv
module iop_decay_cell #(
  parameter int CW           = 32,
  parameter int DECAY_CYCLES = 350000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now,
  input  logic          charge,
  input  logic          charge_val,
  input  logic          consult,
  output logic          value
);
  localparam logic [CW-1:0] SPAN = CW'(DECAY_CYCLES);

  logic          held_q;
  logic          armed_q;
  logic [CW-1:0] expiry_q;
  logic          expired;

  assign expired = armed_q && (now > expiry_q);
  assign value   = expired ? 1'b0 : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      armed_q  <= 1'b0;
      expiry_q <= '0;
    end else if (charge) begin
      held_q   <= charge_val;
      armed_q  <= 1'b1;
      expiry_q <= now + SPAN;
    end else if (consult && expired) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iop_bus_route.sv
module iop_bus_route
  import iop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  byte_t         cpu_wdata,
  input  byte_t         bus_last_byte,
  input  logic          ram_ready,
  input  byte_t         ram_rdata,
  input  byte_t         port_rdata,
  output logic          cpu_ready,
  output byte_t         cpu_rdata,
  output logic          ram_valid,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output byte_t         ram_wdata,
  output sel_e          sel,
  output logic          xfer
);
  logic need_ram;

  always_comb begin
    if (cpu_addr == '0)            sel = SEL_DIR;
    else if (cpu_addr == AW'(1))   sel = SEL_LATCH;
    else                           sel = SEL_MEM;
  end

  assign need_ram  = cpu_we || (sel == SEL_MEM);
  assign ram_valid = cpu_valid && need_ram;
  assign ram_we    = cpu_we;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = (sel == SEL_MEM) ? cpu_wdata : bus_last_byte;
  assign cpu_ready = need_ram ? ram_ready : 1'b1;
  assign cpu_rdata = (sel == SEL_MEM) ? ram_rdata : port_rdata;
  assign xfer      = cpu_valid && cpu_ready;
endmodule

// File: rtl/iop_port_core.sv
module iop_port_core
  import iop_pkg::*;
#(
  parameter int CW           = 32,
  parameter int DECAY_CYCLES = 350000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     now,
  input  logic              wr_dir,
  input  logic              wr_latch,
  input  logic              rd_latch,
  input  byte_t             wval,
  output byte_t             dir_q,
  output byte_t             latch_rd,
  output logic [BANK_W-1:0] bank_sel
);
  byte_t latch_q;
  byte_t pins_q;
  byte_t drive;
  logic [NCELL-1:0] cell_val;

  assign drive    = latch_q | ~dir_q;
  assign bank_sel = drive[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= RST_LATCH;
      pins_q  <= RST_PINS;
    end else if (wr_dir) begin
      if (wval != dir_q) begin
        dir_q  <= wval;
        pins_q <= (pins_q & ~wval) | (latch_q & wval);
      end
    end else if (wr_latch) begin
      if (wval != latch_q) begin
        latch_q <= wval;
        pins_q  <= (pins_q & ~dir_q) | (wval & dir_q);
      end
    end
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    localparam int B = FLOAT_LO + g;
    logic chg, chg_val;
    assign chg     = (wr_dir && dir_q[B] && !wval[B]) || (wr_latch && dir_q[B]);
    assign chg_val = wr_dir ? latch_q[B] : wval[B];
    iop_decay_cell #(.CW(CW), .DECAY_CYCLES(DECAY_CYCLES)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .now        (now),
      .charge     (chg),
      .charge_val (chg_val),
      .consult    (rd_latch && !dir_q[B]),
      .value      (cell_val[g])
    );
  end

  always_comb begin
    latch_rd = drive & (pins_q | PULL_MASK);
    if (!dir_q[SENSE_B]) latch_rd[SENSE_B] = 1'b0;
    for (int g = 0; g < NCELL; g++) begin
      if (!dir_q[FLOAT_LO + g]) latch_rd[FLOAT_LO + g] = cell_val[g];
    end
  end
endmodule

// File: rtl/iop_decay_port.sv
module iop_decay_port
  import iop_pkg::*;
#(
  parameter int AW           = 16,
  parameter int CW           = 32,
  parameter int DECAY_CYCLES = 350000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic [7:0]    bus_last_byte,
  output logic [2:0]    bank_sel,
  output logic          ram_valid,
  input  logic          ram_ready,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata
);
  logic [CW-1:0] now_q;
  sel_e  sel;
  logic  xfer;
  byte_t dir_q, latch_rd, port_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign port_rdata = (sel == SEL_DIR) ? dir_q : latch_rd;

  iop_bus_route #(.AW(AW)) u_route (
    .cpu_valid     (cpu_valid),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .bus_last_byte (bus_last_byte),
    .ram_ready     (ram_ready),
    .ram_rdata     (ram_rdata),
    .port_rdata    (port_rdata),
    .cpu_ready     (cpu_ready),
    .cpu_rdata     (cpu_rdata),
    .ram_valid     (ram_valid),
    .ram_we        (ram_we),
    .ram_addr      (ram_addr),
    .ram_wdata     (ram_wdata),
    .sel           (sel),
    .xfer          (xfer)
  );

  iop_port_core #(.CW(CW), .DECAY_CYCLES(DECAY_CYCLES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .now      (now_q),
    .wr_dir   (xfer && cpu_we && sel == SEL_DIR),
    .wr_latch (xfer && cpu_we && sel == SEL_LATCH),
    .rd_latch (xfer && !cpu_we && sel == SEL_LATCH),
    .wval     (cpu_wdata),
    .dir_q    (dir_q),
    .latch_rd (latch_rd),
    .bank_sel (bank_sel)
  );
endmodule

// File: rtl/iop_decay_port_chk.sv
module iop_decay_port_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [7:0]    cpu_wdata,
  input logic [7:0]    cpu_rdata,
  input logic [7:0]    bus_last_byte,
  input logic [2:0]    bank_sel,
  input logic          ram_valid,
  input logic [AW-1:0] ram_addr,
  input logic [7:0]    ram_wdata,
  input logic [7:0]    ram_rdata,
  input logic [7:0]    dir_q
);
  logic is_port;
  assign is_port = (cpu_addr < AW'(2));

  assert_fwd_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && is_port) |-> (ram_valid && ram_addr == cpu_addr && ram_wdata == bus_last_byte));

  assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !is_port) |-> (ram_valid && ram_addr == cpu_addr &&
      (cpu_we ? (ram_wdata == cpu_wdata) : (cpu_rdata == ram_rdata))));

  assert_port_read_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && is_port) |-> (cpu_ready && !ram_valid));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready) |=> ($stable(bank_sel) && $stable(dir_q)));

  assert_sense_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && cpu_addr == AW'(1) && !dir_q[5]) |-> !cpu_rdata[5]);

  assert_dir_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && cpu_addr == '0) |-> (cpu_rdata == dir_q));
endmodule

bind iop_decay_port iop_decay_port_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_valid     (cpu_valid),
  .cpu_ready     (cpu_ready),
  .cpu_we        (cpu_we),
  .cpu_addr      (cpu_addr),
  .cpu_wdata     (cpu_wdata),
  .cpu_rdata     (cpu_rdata),
  .bus_last_byte (bus_last_byte),
  .bank_sel      (bank_sel),
  .ram_valid     (ram_valid),
  .ram_addr      (ram_addr),
  .ram_wdata     (ram_wdata),
  .ram_rdata     (ram_rdata),
  .dir_q         (dir_q)
);

// File: tb/iop_decay_port_test.sv
`timescale 1ns/1ps
module iop_decay_port_test;
  localparam int AW = 16;
  localparam int D  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, ram_ready = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, bus_last_byte = 8'hE4;
  logic cpu_ready, ram_valid, ram_we;
  logic [7:0] cpu_rdata, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;
  logic [2:0] bank_sel;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] m_dir, m_lat, m_pins;
  logic m_held [2];
  bit   m_arm  [2];
  int   m_exp  [2];

  always #2.5 clk = ~clk;
  assign ram_rdata = ram_addr[7:0] ^ 8'hA5;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  iop_decay_port #(.AW(AW), .CW(32), .DECAY_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_last_byte(bus_last_byte), .bank_sel(bank_sel), .ram_valid(ram_valid),
    .ram_ready(ram_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic charge(int g, logic v);
    m_held[g] = v; m_arm[g] = 1; m_exp[g] = cyc + D;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] v);
    cpu_valid = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
    bus_last_byte = bus_last_byte + 8'h3B;
    #1;
    if (a < 2) chk("R9", ram_wdata, bus_last_byte);
    if (a == 0) begin
      for (int g = 0; g < 2; g++)
        if (m_dir[6+g] && !v[6+g]) charge(g, m_lat[6+g]);
      m_pins = (m_pins & ~v) | (m_lat & v);
      m_dir  = v;
    end else if (a == 1) begin
      for (int g = 0; g < 2; g++)
        if (m_dir[6+g]) charge(g, v[6+g]);
      m_pins = (m_pins & ~m_dir) | (v & m_dir);
      m_lat  = v;
    end
    @(posedge clk); @(negedge clk);
    cpu_valid = 0;
  endtask

  function automatic logic [7:0] exp_rd1();
    logic [7:0] r;
    r = (m_lat | ~m_dir) & (m_pins | 8'h17);
    if (!m_dir[5]) r[5] = 1'b0;
    for (int g = 0; g < 2; g++)
      if (!m_dir[6+g]) r[6+g] = (m_arm[g] && cyc > m_exp[g]) ? 1'b0 : m_held[g];
    return r;
  endfunction

  task automatic rd1(string req);
    logic [7:0] e;
    cpu_valid = 1; cpu_we = 0; cpu_addr = 1;
    #1;
    e = exp_rd1();
    chk(req, cpu_rdata, e);
    for (int g = 0; g < 2; g++)
      if (!m_dir[6+g] && m_arm[g] && cyc > m_exp[g]) begin m_arm[g] = 0; m_held[g] = 0; end
    @(posedge clk); @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic rd0();
    cpu_valid = 1; cpu_we = 0; cpu_addr = 0;
    #1;
    chk("R12", cpu_rdata, m_dir);
    @(posedge clk); @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic chk_bank();
    chk("R4", {5'b0, bank_sel}, {5'b0, (m_lat[2:0] | ~m_dir[2:0])});
  endtask

  initial begin
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'h3F, 8'hC0, 8'hA5, 8'h5A, 8'h40, 8'h80};
    int e;
    m_dir = 8'h00; m_lat = 8'h3F; m_pins = 8'h3F;
    for (int g = 0; g < 2; g++) begin m_held[g] = 0; m_arm[g] = 0; m_exp[g] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    chk("R1", {5'b0, bank_sel}, 8'h07);
    rd0();
    rd1("R1");

    // R2 R3 R4 R5 R6 R7 sweep over every direction mask
    for (int d = 0; d < 256; d++) begin
      wr(0, 8'(d));
      chk_bank();
      rd0();
      for (int p = 0; p < 8; p++) begin
        wr(1, pats[p]);
        chk_bank();
        rd1("R2_R3_R5_R6_R7");
      end
    end

    // R8 expiry boundary: charge bit 6 = 1, bit 7 = 0 via direction fall
    wr(0, 8'hC0); wr(1, 8'h40); wr(0, 8'h00);
    e = m_exp[0];
    while (cyc < e) @(negedge clk);
    chk("R8", cpu_rdata & 8'h00, 8'h00);
    rd1("R8");                // at expiry cycle: still 1
    rd1("R8");                // one later: 0, cell emptied
    wr(1, 8'hFF);             // input bits: no recharge (R7)
    rd1("R8");

    // R9 / R10 RAM path
    wr(16'h1234, 8'h9C);
    cpu_valid = 1; cpu_we = 1; cpu_addr = 16'h0777; cpu_wdata = 8'h6D; #1;
    chk("R10", ram_wdata, 8'h6D);
    chk("R10", {7'b0, ram_valid}, 8'h01);
    cpu_we = 0; cpu_addr = 16'h0200; #1;
    chk("R10", cpu_rdata, 8'h00 ^ 8'hA5);
    @(negedge clk); cpu_valid = 0;

    // R11 back-pressure: stalled write to the latch has no effect
    ram_ready = 0;
    cpu_valid = 1; cpu_we = 1; cpu_addr = 1; cpu_wdata = ~m_lat; #1;
    chk("R11", {7'b0, cpu_ready}, 8'h00);
    @(posedge clk); @(negedge clk); cpu_valid = 0;
    chk_bank();
    rd1("R11");
    cpu_valid = 1; cpu_we = 0; cpu_addr = 0; #1;
    chk("R11", {7'b0, cpu_ready}, 8'h01);
    @(negedge clk); cpu_valid = 0;
    ram_ready = 1;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule